// File: doc/BRIEF.md
# Sequential Floating-Point Adder with Exponent Alignment

This block adds two floating-point words over several clock cycles. Each word holds a sign bit, an unsigned exponent and a magnitude mantissa whose top bit carries the weight just left of the binary point. A one-cycle `start` pulse captures both operands. The block then compares their exponents and picks one of five paths:

- the exponents are equal;
- the Y mantissa must be aligned;
- the X mantissa must be aligned;
- the result is X unchanged;
- the result is Y unchanged.

Alignment moves the smaller operand's mantissa right one place per cycle and raises that operand's exponent each time. The two mantissas are then added or subtracted, depending on their signs. The sum is renormalised one bit per cycle, and `done` pulses as the finished word appears on `result`.

The block is meant for a datapath that can wait a data-dependent number of cycles for each sum. Rounding, special values and subnormal numbers are not handled. Exponent arithmetic wraps modulo two to the exponent width. Callers keep their operands far enough from the exponent limits that no wrap occurs.

Top module: `fpa_align_adder`

## Requirements
- R1: A word is {sign at bit 24, exponent at bits 23:16, mantissa at bits 15:0} for the default widths. Sign 1 means negative. The value is mantissa/2^15 times 2^exponent (relative scale). `result` uses the same layout.
- R2: `start` seen in the idle state captures `op_x` and `op_y`. A `start` pulse while an operation is running is ignored: that operation's result is unaffected and no extra `done` follows.
- R3: When both exponents are equal, the mantissas are combined without any shift, and the common exponent is the starting result exponent.
- R4: When the exponent gap is below the mantissa width (16), the smaller-exponent mantissa is shifted right by the gap before the add. Bits shifted out are dropped. Each single-place shift raises that operand's exponent by one.
- R5: When the exponent gap is 16 or more, `result` equals the larger-exponent operand bit for bit. `done` is high two clock edges after the edge that samples `start`.
- R6: Operands with equal signs have their mantissas added, and the result keeps that sign.
- R7: Operands with different signs give the larger mantissa minus the smaller, taking the sign of the larger after alignment.
- R8: A carry out of the mantissa sum shifts the sum right one place and raises the exponent by one.
- R9: While bit 15 of a non-zero sum is 0, the sum shifts left one place and the exponent drops by one. A non-zero result therefore always has mantissa bit 15 set.
- R10: A sum of zero gives an all-zero `result`.
- R11: `done` is a single-cycle pulse. `result` holds its value until the next completion. Reset clears both to zero.
- R12: With equal exponents and a sum that needs no normalising shift, `done` is high four clock edges after the edge that samples `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an addition (idle only) |
| op_x | input | 25 | First operand word |
| op_y | input | 25 | Second operand word |
| result | output | 25 | Sum word, held between completions |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situations to reach from the ports are the two edges of the alignment decision and a full-length left normalisation. These are a gap of exactly 15 versus exactly 16, and a near-cancelling difference of unlike signs that must walk the leading one across all mantissa places. Directed cases place the operands on both sides of the gap boundary and build differences of one unit. Random cases draw the second exponent within a narrow window around the first, so that short alignments, copies and cancellations all occur often. A `start` pulse injected midway through an alignment checks that a running operation ignores it.

// File: rtl/fpa_pkg.sv
`timescale 1ns/1ps
// Shared types for the sequential floating-point adder.
// Assumes nothing beyond the enclosing design modules.
package fpa_pkg;

    // Controller states.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_CMP     = 3'd1,
        ST_ALIGN_X = 3'd2,
        ST_ALIGN_Y = 3'd3,
        ST_ADD     = 3'd4,
        ST_NORM    = 3'd5
    } fpa_state_e;

    // Command to one operand register.
    typedef enum logic [1:0] {
        OPR_HOLD = 2'd0,
        OPR_LOAD = 2'd1,
        OPR_SHR  = 2'd2
    } opr_cmd_e;

    // Command to the result accumulator.
    typedef enum logic [1:0] {
        ACC_HOLD = 2'd0,
        ACC_LOAD = 2'd1,
        ACC_SHR  = 2'd2,
        ACC_SHL  = 2'd3
    } acc_cmd_e;

endpackage

// File: rtl/fpa_operand_reg.sv
`timescale 1ns/1ps
// Operand register: holds sign, exponent and mantissa of one operand.
// A shift command moves the mantissa right one place (LSB dropped) and
// raises the exponent by one, so the value is kept apart from truncation.
// Assumes the controller never loads and shifts in the same cycle.
module fpa_operand_reg
    import fpa_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  opr_cmd_e         cmd,
    input  logic             ld_sign,
    input  logic [EXP_W-1:0] ld_exp,
    input  logic [MAN_W-1:0] ld_man,
    output logic             sign,
    output logic [EXP_W-1:0] exp_q,
    output logic [MAN_W-1:0] man_q
);

    // Capture, align-shift or hold the operand fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sign  <= 1'b0;
            exp_q <= '0;
            man_q <= '0;
        end else begin
            case (cmd)
                OPR_LOAD: begin
                    sign  <= ld_sign;
                    exp_q <= ld_exp;
                    man_q <= ld_man;
                end
                OPR_SHR: begin
                    exp_q <= exp_q + EXP_W'(1);
                    man_q <= man_q >> 1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/fpa_mant_addsub.sv
`timescale 1ns/1ps
// Signed-magnitude mantissa adder/subtractor (combinational).
// Like signs: magnitudes added, carry kept in the top bit.
// Unlike signs: smaller magnitude taken from the larger; sign follows
// the larger. Assumes both mantissas are already aligned.
module fpa_mant_addsub #(
    parameter int MAN_W = 16
) (
    input  logic             sx,
    input  logic [MAN_W-1:0] mx,
    input  logic             sy,
    input  logic [MAN_W-1:0] my,
    output logic [MAN_W:0]   sum,
    output logic             sum_sign
);

    logic [MAN_W:0] ext_x;
    logic [MAN_W:0] ext_y;

    // Widen both operands by one bit for the carry.
    always_comb begin
        ext_x = {1'b0, mx};
        ext_y = {1'b0, my};
    end

    // Choose add or ordered subtract and the sign that goes with it.
    always_comb begin
        if (sx == sy) begin
            sum      = ext_x + ext_y;
            sum_sign = sx;
        end else if (mx >= my) begin
            sum      = ext_x - ext_y;
            sum_sign = sx;
        end else begin
            sum      = ext_y - ext_x;
            sum_sign = sy;
        end
    end

endmodule

// File: rtl/fpa_norm_acc.sv
`timescale 1ns/1ps
// Result accumulator with a one-place bidirectional shifter and an
// exponent incrementer/decrementer used for normalisation.
// Assumes the controller issues at most one command per cycle.
module fpa_norm_acc
    import fpa_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  acc_cmd_e         cmd,
    input  logic             ld_sign,
    input  logic [EXP_W-1:0] ld_exp,
    input  logic [MAN_W:0]   ld_sum,
    output logic             sign,
    output logic [EXP_W-1:0] exp_q,
    output logic [MAN_W:0]   acc_q
);

    // Load a raw sum or shift it one place with exponent correction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sign  <= 1'b0;
            exp_q <= '0;
            acc_q <= '0;
        end else begin
            case (cmd)
                ACC_LOAD: begin
                    sign  <= ld_sign;
                    exp_q <= ld_exp;
                    acc_q <= ld_sum;
                end
                ACC_SHR: begin
                    exp_q <= exp_q + EXP_W'(1);
                    acc_q <= acc_q >> 1;
                end
                ACC_SHL: begin
                    exp_q <= exp_q - EXP_W'(1);
                    acc_q <= acc_q << 1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/fpa_ctrl.sv
`timescale 1ns/1ps
// Control FSM: loads the operands, compares the exponents, steps the
// alignment, triggers the add and walks the normalisation. Finish strobes
// tell the top which value becomes the result.
// Assumes the operand and accumulator registers follow the commands it gives.
module fpa_ctrl
    import fpa_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [EXP_W-1:0] ex,
    input  logic [EXP_W-1:0] ey,
    input  logic [MAN_W:0]   acc,
    output opr_cmd_e         x_cmd,
    output opr_cmd_e         y_cmd,
    output acc_cmd_e         acc_cmd,
    output fpa_state_e       state,
    output logic             fin_copy_x,
    output logic             fin_copy_y,
    output logic             fin_zero,
    output logic             fin_norm
);

    localparam logic [EXP_W:0] GAP_LIM = (EXP_W+1)'(MAN_W);

    fpa_state_e     nxt;
    logic [EXP_W:0] gap_xy;
    logic [EXP_W:0] gap_yx;

    // Exponent gaps in both directions, one bit wider than the exponent.
    always_comb begin
        gap_xy = {1'b0, ex} - {1'b0, ey};
        gap_yx = {1'b0, ey} - {1'b0, ex};
    end

    // Next-state and command decode.
    always_comb begin
        nxt        = state;
        x_cmd      = OPR_HOLD;
        y_cmd      = OPR_HOLD;
        acc_cmd    = ACC_HOLD;
        fin_copy_x = 1'b0;
        fin_copy_y = 1'b0;
        fin_zero   = 1'b0;
        fin_norm   = 1'b0;
        case (state)
            ST_IDLE: begin
                if (start) begin
                    x_cmd = OPR_LOAD;
                    y_cmd = OPR_LOAD;
                    nxt   = ST_CMP;
                end
            end
            ST_CMP: begin
                if (ex == ey) begin
                    nxt = ST_ADD;
                end else if (ex > ey) begin
                    if (gap_xy >= GAP_LIM) begin
                        fin_copy_x = 1'b1;
                        nxt        = ST_IDLE;
                    end else begin
                        nxt = ST_ALIGN_Y;
                    end
                end else begin
                    if (gap_yx >= GAP_LIM) begin
                        fin_copy_y = 1'b1;
                        nxt        = ST_IDLE;
                    end else begin
                        nxt = ST_ALIGN_X;
                    end
                end
            end
            ST_ALIGN_X: begin
                if (ex == ey) nxt = ST_ADD;
                else          x_cmd = OPR_SHR;
            end
            ST_ALIGN_Y: begin
                if (ex == ey) nxt = ST_ADD;
                else          y_cmd = OPR_SHR;
            end
            ST_ADD: begin
                acc_cmd = ACC_LOAD;
                nxt     = ST_NORM;
            end
            ST_NORM: begin
                if (acc == '0) begin
                    fin_zero = 1'b1;
                    nxt      = ST_IDLE;
                end else if (acc[MAN_W]) begin
                    acc_cmd = ACC_SHR;
                end else if (!acc[MAN_W-1]) begin
                    acc_cmd = ACC_SHL;
                end else begin
                    fin_norm = 1'b1;
                    nxt      = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

endmodule

// File: rtl/fpa_align_adder.sv
`timescale 1ns/1ps
// Top of the sequential floating-point adder. Two operand registers, a
// shared mantissa adder/subtractor, a normalising accumulator and the
// control FSM. Result and done are registered.
// Assumes callers avoid exponent wrap; no rounding or special values.
module fpa_align_adder
    import fpa_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 16,
    localparam int WORD_W = 1 + EXP_W + MAN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] op_x,
    input  logic [WORD_W-1:0] op_y,
    output logic [WORD_W-1:0] result,
    output logic              done
);

    opr_cmd_e         x_cmd;
    opr_cmd_e         y_cmd;
    acc_cmd_e         acc_cmd;
    fpa_state_e       ctl_state;
    logic             fin_copy_x;
    logic             fin_copy_y;
    logic             fin_zero;
    logic             fin_norm;
    logic             x_sign;
    logic             y_sign;
    logic [EXP_W-1:0] x_exp;
    logic [EXP_W-1:0] y_exp;
    logic [MAN_W-1:0] x_man;
    logic [MAN_W-1:0] y_man;
    logic [MAN_W:0]   raw_sum;
    logic             raw_sign;
    logic             acc_sign;
    logic [EXP_W-1:0] acc_exp;
    logic [MAN_W:0]   acc_man;

    fpa_operand_reg #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_opx (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (x_cmd),
        .ld_sign (op_x[WORD_W-1]),
        .ld_exp  (op_x[MAN_W +: EXP_W]),
        .ld_man  (op_x[MAN_W-1:0]),
        .sign    (x_sign),
        .exp_q   (x_exp),
        .man_q   (x_man)
    );

    fpa_operand_reg #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_opy (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (y_cmd),
        .ld_sign (op_y[WORD_W-1]),
        .ld_exp  (op_y[MAN_W +: EXP_W]),
        .ld_man  (op_y[MAN_W-1:0]),
        .sign    (y_sign),
        .exp_q   (y_exp),
        .man_q   (y_man)
    );

    fpa_mant_addsub #(.MAN_W(MAN_W)) u_addsub (
        .sx       (x_sign),
        .mx       (x_man),
        .sy       (y_sign),
        .my       (y_man),
        .sum      (raw_sum),
        .sum_sign (raw_sign)
    );

    fpa_norm_acc #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (acc_cmd),
        .ld_sign (raw_sign),
        .ld_exp  (x_exp),
        .ld_sum  (raw_sum),
        .sign    (acc_sign),
        .exp_q   (acc_exp),
        .acc_q   (acc_man)
    );

    fpa_ctrl #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .ex         (x_exp),
        .ey         (y_exp),
        .acc        (acc_man),
        .x_cmd      (x_cmd),
        .y_cmd      (y_cmd),
        .acc_cmd    (acc_cmd),
        .state      (ctl_state),
        .fin_copy_x (fin_copy_x),
        .fin_copy_y (fin_copy_y),
        .fin_zero   (fin_zero),
        .fin_norm   (fin_norm)
    );

    // Latch the finished word and raise the one-cycle completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= fin_copy_x | fin_copy_y | fin_zero | fin_norm;
            if (fin_copy_x)     result <= {x_sign, x_exp, x_man};
            else if (fin_copy_y) result <= {y_sign, y_exp, y_man};
            else if (fin_zero)   result <= '0;
            else if (fin_norm)   result <= {acc_sign, acc_exp, acc_man[MAN_W-1:0]};
        end
    end

endmodule

// File: rtl/fpa_align_adder_chk.sv
`timescale 1ns/1ps
// Assertion checker for the floating-point adder, bound to the top.
// Watches the completion handshake, the alignment stepping, the
// normalised output and the operand hold while busy.
module fpa_align_adder_chk
    import fpa_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 16,
    localparam int WORD_W = 1 + EXP_W + MAN_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic [WORD_W-1:0] result,
    input fpa_state_e        state,
    input logic              sx,
    input logic              sy,
    input logic [EXP_W-1:0]  ex,
    input logic [EXP_W-1:0]  ey
);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(state) == ST_NORM && result[MAN_W-1:0] == '0) |-> result == '0);

    // R9
    norm_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(state) == ST_NORM && result != '0) |-> result[MAN_W-1]);

    // R4
    align_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ALIGN_Y && ex != ey) |=> (ey == $past(ey) + EXP_W'(1)) && $stable(ex));

    // R4
    align_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ALIGN_X) |-> (ey >= ex));

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> ($stable(sx) && $stable(sy)));

endmodule

bind fpa_align_adder fpa_align_adder_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .done   (done),
    .result (result),
    .state  (ctl_state),
    .sx     (x_sign),
    .sy     (y_sign),
    .ex     (x_exp),
    .ey     (y_exp)
);

// File: tb/fpa_align_adder_bench.sv
`timescale 1ns/1ps
module fpa_align_adder_bench;

    localparam int EW = 8;
    localparam int MW = 16;
    localparam int W  = 1 + EW + MW;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] op_x = '0;
    logic [W-1:0] op_y = '0;
    logic [W-1:0] result;
    logic         done;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    fpa_align_adder #(.EXP_W(EW), .MAN_W(MW)) u_fpa_align_adder (
        .clk(clk), .rst_n(rst_n), .start(start),
        .op_x(op_x), .op_y(op_y), .result(result), .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp_v);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    function automatic logic [W-1:0] pack(input logic s, input logic [EW-1:0] e,
                                          input logic [MW-1:0] m);
        return {s, e, m};
    endfunction

    // Expected sum from the requirements (R3..R10).
    function automatic logic [W-1:0] ref_add(input logic [W-1:0] x, input logic [W-1:0] y);
        logic          sx, sy, s;
        int            ex, ey, e;
        logic [MW-1:0] mx, my;
        logic [MW:0]   sum;
        sx = x[W-1]; ex = int'(x[MW +: EW]); mx = x[MW-1:0];
        sy = y[W-1]; ey = int'(y[MW +: EW]); my = y[MW-1:0];
        if (ex > ey) begin
            if (ex - ey >= MW) return x;
            my = my >> (ex - ey);
            e = ex;
        end else if (ey > ex) begin
            if (ey - ex >= MW) return y;
            mx = mx >> (ey - ex);
            e = ey;
        end else begin
            e = ex;
        end
        if (sx == sy) begin
            sum = {1'b0, mx} + {1'b0, my}; s = sx;
        end else if (mx >= my) begin
            sum = {1'b0, mx} - {1'b0, my}; s = sx;
        end else begin
            sum = {1'b0, my} - {1'b0, mx}; s = sy;
        end
        if (sum == '0) return '0;
        if (sum[MW]) begin
            sum = sum >> 1; e = e + 1;
        end
        for (int i = 0; i < MW; i++) begin
            if (!sum[MW-1]) begin
                sum = sum << 1; e = e - 1;
            end
        end
        return {s, EW'(e), sum[MW-1:0]};
    endfunction

    // Run one addition; check the result and, if exp_lat > 0, the latency.
    task automatic run_op(input logic [W-1:0] x, input logic [W-1:0] y,
                          input string req, input int exp_lat);
        int lat;
        @(negedge clk);
        op_x = x; op_y = y; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        check(done == 1'b1, {req, " done seen"}, W'(done), W'(1));
        check(result == ref_add(x, y), req, result, ref_add(x, y));
        if (exp_lat > 0)
            check(lat == exp_lat, {req, " latency"}, W'(lat), W'(exp_lat));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [W-1:0] a, b;
        int           extra;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(done == 1'b0, "R11 reset done", W'(done), '0);
        check(result == '0, "R11 reset result", result, '0);

        // R3 R6 R8: equal exponents, like signs, carry out
        run_op(pack(0, 8'd100, 16'hC000), pack(0, 8'd100, 16'hA000), "R3 R6 R8 carry", 0);
        // R12: equal exponents, no normalising shift
        run_op(pack(0, 8'd50, 16'h8000), pack(0, 8'd50, 16'h0000), "R12 latency", 4);
        // R10 R7: exact cancellation
        run_op(pack(0, 8'd70, 16'h9ABC), pack(1, 8'd70, 16'h9ABC), "R10 R7 cancel", 0);
        // R9: difference of one unit, full left walk
        run_op(pack(0, 8'd80, 16'h8001), pack(1, 8'd80, 16'h8000), "R9 left walk", 0);
        // R7 R4: unlike signs, Y larger after aligning X by 2
        run_op(pack(0, 8'd90, 16'h8000), pack(1, 8'd92, 16'hC000), "R7 R4 unlike", 0);
        // R4: gap of 15 still aligns, truncation
        run_op(pack(0, 8'd120, 16'h8000), pack(0, 8'd105, 16'hFFFF), "R4 gap15", 0);
        // R5: gap of 16 copies X
        run_op(pack(1, 8'd130, 16'hABCD), pack(0, 8'd114, 16'hFFFF), "R5 copy x", 2);
        // R5: large gap copies Y
        run_op(pack(0, 8'd30, 16'h9999), pack(1, 8'd70, 16'hC001), "R5 copy y", 2);
        // R1: sign and field positions in a negative sum
        run_op(pack(1, 8'd40, 16'h8000), pack(1, 8'd40, 16'h8000), "R1 R6 negative", 0);

        // R2: start during alignment is ignored
        a = pack(0, 8'd60, 16'h8000);
        b = pack(0, 8'd70, 16'hC000);
        @(negedge clk);
        op_x = a; op_y = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        op_x = pack(1, 8'd10, 16'hFFFF); op_y = pack(1, 8'd10, 16'hFFFF); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        begin
            int guard = 0;
            while (!done && guard < 200) begin
                @(negedge clk);
                guard++;
            end
        end
        check(result == ref_add(a, b), "R2 busy start ignored", result, ref_add(a, b));
        extra = 0;
        repeat (40) begin
            @(negedge clk);
            if (done) extra++;
        end
        check(extra == 0, "R2 no extra done", W'(extra), '0);
        // R11: result held after completion
        check(result == ref_add(a, b), "R11 result held", result, ref_add(a, b));

        // Random mix around the alignment boundary (R3..R10)
        for (int k = 0; k < 400; k++) begin
            int ex_r, ey_r;
            logic [MW-1:0] mx_r, my_r;
            ex_r = 40 + int'($urandom % 170);
            ey_r = ex_r + int'($urandom % 41) - 20;
            mx_r = MW'($urandom) | 16'h8000;
            my_r = MW'($urandom) | 16'h8000;
            if ($urandom % 8 == 0) my_r = mx_r ^ MW'($urandom % 4);
            run_op(pack(1'($urandom), EW'(ex_r), mx_r), pack(1'($urandom), EW'(ey_r), my_r),
                   "R4 R5 R7 R9 random", 0);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule